// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits through a long start-up pause and then issues a burst of CAS-before-RAS (CBR) wake-up cycles. Only then does it report that normal accesses may begin. From that point it owes the memory one CBR refresh per fixed interval. Each refresh is requested from the access controller through a request/grant handshake. Once granted, the block drives RAS# and CAS# itself for a short, fixed pulse pattern. The address bus is not used, because the memory steps its own internal row counter during CBR.

Refresh slots that fall due while the grant is withheld are counted, up to a small cap, and are then run back to back once the bus is handed over. The block also watches the shared RAS# line, which is low when either the block or the access controller holds it low. If that line stays high for longer than the retention limit, the memory must be woken again. The block then drops its ready flag and repeats the wake-up burst without the start-up pause.

All times are parameters counted in clock cycles. The defaults suit a 100 MHz clock:

- a 500 µs pause,
- 8 wake-up cycles,
- one refresh every 15.6 µs, which keeps 1024 rows within 16.4 ms,
- a 16.4 ms idle limit.

Top module: `dram_rfsh_seq`

## Requirements
- R1: During and right after reset, ras_n_o and cas_n_o are 1, and ref_req_o, drive_en_o and init_done_o are 0.
- R2: ref_req_o stays 0 for the first PAUSE_CYC clock edges after reset is released. It rises on edge PAUSE_CYC+1.
- R3: Exactly INIT_CNT CBR cycles follow the pause. init_done_o rises on the edge that ends the precharge of the last of them, and not earlier.
- R4: In every CBR cycle, CAS# falls while RAS# is high, exactly T_CSR cycles before RAS# falls. CAS# then stays low for exactly T_CHR cycles after RAS# falls.
- R5: RAS# stays low for exactly T_RAS cycles in every CBR cycle. Between one RAS# rise and the next RAS# fall there are at least T_RP+T_CSR cycles.
- R6: RAS# or CAS# is driven low only while drive_en_o is 1. drive_en_o rises only on an edge at which ref_gnt_i is 1. No CBR cycle starts while the grant is withheld.
- R7: Once init_done_o is 1, refresh slots fall due every REF_INTERVAL cycles. The first slot is REF_INTERVAL cycles after init_done_o rises. With the grant held high, each RAS# fall comes 3 cycles after its slot.
- R8: Slots that fall due while the grant is withheld are kept, up to MAX_OWED; further slots are dropped. When the grant arrives, the kept slots run back to back, one RAS# fall every T_CSR+T_RAS+T_RP+1 cycles.
- R9: After IDLE_LIMIT consecutive cycles with the shared RAS# high, init_done_o falls. Owed slots are discarded, and INIT_CNT CBR cycles run again without a pause, the first RAS# fall two cycles after the grant is seen.
- R10: A low level on ext_ras_n_i restarts the idle count, so periodic external activity keeps init_done_o at 1 even while refresh is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_gnt_i | input | 1 | Bus handed to the sequencer; held while ref_req_o is 1 |
| ext_ras_n_i | input | 1 | RAS# as driven by the access controller, watched for activity |
| ref_req_o | output | 1 | Sequencer wants the bus for one or more CBR cycles |
| ras_n_o | output | 1 | RAS# from the sequencer, active low |
| cas_n_o | output | 1 | CAS# from the sequencer, active low |
| drive_en_o | output | 1 | Sequencer owns the RAS#/CAS# lines |
| init_done_o | output | 1 | Wake-up burst complete; normal accesses allowed |

## Verification
The interval timer keeps producing slots while the grant is withheld. It also produces them while a back-to-back burst is running, so a new slot can fall due in the same cycle in which a refresh completes. The bench provokes this in two ways. It withholds the grant across four slots, which checks the cap on owed slots. It then re-grants and checks the exact number and spacing of RAS# falls before the next slot. Idle expiry competing with pending slots is provoked by withholding the grant beyond the idle limit. The judgement there is that the backlog is dropped: after the repeat wake-up burst, the first refresh appears exactly one interval later.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  // Life phases of the sequencer
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // CBR pulse engine states
  typedef enum logic [2:0] {
    EN_IDLE = 3'd0,
    EN_WAIT = 3'd1,
    EN_CSR  = 3'd2,
    EN_CHR  = 3'd3,
    EN_RLO  = 3'd4,
    EN_PRE  = 3'd5
  } eng_e;

endpackage

// File: rtl/rfsh_timer.sv
// Free-running cycle counter: pulses tick on the LIMIT-th enabled cycle.
module rfsh_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  assign tick = en && !clr && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_debt.sv
// Saturating count of refresh slots that are due but not yet served.
module rfsh_debt #(
  parameter int MAX_OWED = 4,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10: if (owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
        2'b01: if (owed != '0) owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/cbr_engine.sv
// Produces one CBR pulse pattern per demanded refresh once the bus is granted.
module cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 2,
  parameter int T_RAS = 7,
  parameter int T_RP  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic demand_i,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic drive_en_o,
  output logic done_o
);
  localparam int T_RLO = T_RAS - T_CHR;
  localparam int M1    = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int M2    = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX  = (M1 > M2) ? M1 : M2;
  localparam int TW    = $clog2(TMAX + 1);

  eng_e          st_q;
  logic [TW-1:0] tmr_q;

  assign done_o = (st_q == EN_PRE) && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= EN_IDLE;
      tmr_q      <= '0;
      req_o      <= 1'b0;
      ras_n_o    <= 1'b1;
      cas_n_o    <= 1'b1;
      drive_en_o <= 1'b0;
    end else begin
      unique case (st_q)
        EN_IDLE: begin
          if (demand_i) begin
            st_q  <= EN_WAIT;
            req_o <= 1'b1;
          end
        end
        EN_WAIT: begin
          if (!demand_i) begin
            st_q       <= EN_IDLE;
            req_o      <= 1'b0;
            drive_en_o <= 1'b0;
          end else if (gnt_i) begin
            st_q       <= EN_CSR;
            cas_n_o    <= 1'b0;
            drive_en_o <= 1'b1;
            tmr_q      <= TW'(T_CSR - 1);
          end
        end
        EN_CSR: begin
          if (tmr_q == '0) begin
            st_q    <= EN_CHR;
            ras_n_o <= 1'b0;
            tmr_q   <= TW'(T_CHR - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        EN_CHR: begin
          if (tmr_q == '0) begin
            st_q    <= EN_RLO;
            cas_n_o <= 1'b1;
            tmr_q   <= TW'(T_RLO - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        EN_RLO: begin
          if (tmr_q == '0) begin
            st_q    <= EN_PRE;
            ras_n_o <= 1'b1;
            tmr_q   <= TW'(T_RP - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        EN_PRE: begin
          if (tmr_q == '0) begin
            st_q <= EN_WAIT;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_seq.sv
// Power-up, periodic CBR refresh and idle re-wake sequencer.
// Timing parameters are in clock cycles; T_CHR >= 1, T_RAS > T_CHR, T_CSR >= 1, T_RP >= 1.
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int INIT_CNT     = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int IDLE_LIMIT   = 1640000,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 7,
  parameter int T_RP         = 5,
  parameter int MAX_OWED     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt_i,
  input  logic ext_ras_n_i,
  output logic ref_req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic drive_en_o,
  output logic init_done_o
);
  localparam int IW = $clog2(INIT_CNT + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  phase_e        phase_q;
  logic [IW-1:0] init_left_q;
  logic [OW-1:0] owed_q;
  logic          pause_tick;
  logic          ivl_tick;
  logic          idle_tick;
  logic          bus_idle;
  logic          in_run;
  logic          demand;
  logic          cyc_done;

  assign in_run   = (phase_q == PH_RUN);
  assign bus_idle = ras_n_o && ext_ras_n_i;

  rfsh_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst  (rst),
    .clr  (1'b0),
    .en   (phase_q == PH_PAUSE),
    .tick (pause_tick)
  );

  rfsh_timer #(.LIMIT(REF_INTERVAL)) u_ivl (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_run),
    .en   (in_run),
    .tick (ivl_tick)
  );

  rfsh_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_run || !bus_idle),
    .en   (in_run && bus_idle),
    .tick (idle_tick)
  );

  rfsh_debt #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_run || idle_tick),
    .inc  (ivl_tick),
    .dec  (cyc_done && in_run),
    .owed (owed_q)
  );

  always_comb begin
    unique case (phase_q)
      PH_INIT: demand = (init_left_q != '0);
      PH_RUN:  demand = (owed_q != '0);
      default: demand = 1'b0;
    endcase
  end

  cbr_engine #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .demand_i   (demand),
    .gnt_i      (ref_gnt_i),
    .req_o      (ref_req_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .drive_en_o (drive_en_o),
    .done_o     (cyc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_PAUSE;
      init_left_q <= '0;
      init_done_o <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: begin
          if (pause_tick) begin
            phase_q     <= PH_INIT;
            init_left_q <= IW'(INIT_CNT);
          end
        end
        PH_INIT: begin
          if (cyc_done) begin
            init_left_q <= init_left_q - 1'b1;
            if (init_left_q == IW'(1)) begin
              phase_q     <= PH_RUN;
              init_done_o <= 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (idle_tick) begin
            phase_q     <= PH_INIT;
            init_left_q <= IW'(INIT_CNT);
            init_done_o <= 1'b0;
          end
        end
        default: phase_q <= PH_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk
  import dram_rfsh_pkg::*;
#(
  parameter int OW       = 3,
  parameter int MAX_OWED = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ras_n,
  input logic          cas_n,
  input logic          drive_en,
  input logic          gnt,
  input logic          req,
  input logic          init_done,
  input phase_e        phase,
  input logic [OW-1:0] owed
);
  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAUSE) |-> !req);

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && ($past(cas_n) == 1'b0)));

  // R5
  ras_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> !ras_n);

  // R6
  own_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> drive_en);

  // R6
  grant_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> $past(gnt));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (ras_n && cas_n));

  // R8
  debt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    owed <= OW'(MAX_OWED));

  // R9
  redo_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_done) |-> (phase == PH_INIT));
endmodule

bind dram_rfsh_seq dram_rfsh_chk #(.OW(OW), .MAX_OWED(MAX_OWED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n_o),
  .cas_n     (cas_n_o),
  .drive_en  (drive_en_o),
  .gnt       (ref_gnt_i),
  .req       (ref_req_o),
  .init_done (init_done_o),
  .phase     (phase_q),
  .owed      (owed_q)
);

// File: tb/tb_dram_rfsh_seq.sv
`timescale 1ns/1ps
module tb_dram_rfsh_seq;
  localparam int PAUSE  = 40;
  localparam int NINIT  = 8;
  localparam int REF    = 60;
  localparam int IDLE   = 400;
  localparam int TCSR   = 1;
  localparam int TCHR   = 2;
  localparam int TRAS   = 4;
  localparam int TRP    = 3;
  localparam int MOWED  = 3;
  localparam int BTB    = TCSR + TRAS + TRP + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b1;
  logic ext_ras_n = 1'b1;
  logic req, ras_n, cas_n, drv, idone;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int fall_cnt = 0;
  int last_fall = 0;
  int last_rise = -1000;
  int cas_lead = 0;
  int ras_len = 0;
  int chr_len = 0;
  int viol = 0;
  logic prev_ras = 1'b1;

  always #5 clk = ~clk;

  dram_rfsh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CNT(NINIT), .REF_INTERVAL(REF), .IDLE_LIMIT(IDLE),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP), .MAX_OWED(MOWED)
  ) dut (
    .clk(clk), .rst(rst), .ref_gnt_i(gnt), .ext_ras_n_i(ext_ras_n),
    .ref_req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .drive_en_o(drv), .init_done_o(idone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Port monitor sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; fall_cnt = 0; last_rise = -1000; cas_lead = 0;
      ras_len = 0; chr_len = 0; prev_ras = 1'b1;
    end else begin
      cyc++;
      if ((!ras_n || !cas_n) && !drv) viol++;
      if (prev_ras && !ras_n) begin
        fall_cnt++;
        last_fall = cyc;
        check(cas_n == 1'b0, "R4 cas low at ras fall", cas_n, 0);
        check(cas_lead == TCSR, "R4 cas lead", cas_lead, TCSR);
        check(cyc - last_rise >= TRP + TCSR, "R5 precharge gap", cyc - last_rise, TRP + TCSR);
        cas_lead = 0;
      end
      if (!prev_ras && ras_n) begin
        check(ras_len == TRAS, "R5 ras low width", ras_len, TRAS);
        check(chr_len == TCHR, "R4 cas hold", chr_len, TCHR);
        ras_len = 0; chr_len = 0;
        last_rise = cyc;
      end
      if (!ras_n) begin
        ras_len++;
        if (!cas_n) chr_len++;
      end else if (!cas_n) begin
        cas_lead++;
      end else begin
        cas_lead = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_fall(output int t);
    int base = fall_cnt;
    for (int i = 0; i < 3000; i++) begin
      if (fall_cnt != base) break;
      step();
    end
    check(fall_cnt != base, "R7 fall timeout", fall_cnt, base + 1);
    t = last_fall;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 100; i++) begin
      if (ras_n) break;
      step();
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, ta, tb, c, base;
    repeat (5) step();
    // R1 reset state
    check(ras_n && cas_n, "R1 strobes idle", {ras_n, cas_n}, 3);
    check(!req && !drv && !idone, "R1 outputs low", {req, drv, idone}, 0);
    rst = 1'b0;
    // R2 pause
    repeat (PAUSE) step();
    check(req == 1'b0, "R2 no request in pause", req, 0);
    check(fall_cnt == 0, "R2 no cycles in pause", fall_cnt, 0);
    step();
    check(req == 1'b1, "R2 request after pause", req, 1);
    // R3 wake-up burst
    repeat (71) step();
    check(idone == 1'b0, "R3 init_done early", idone, 0);
    step();
    check(idone == 1'b1, "R3 init_done rise", idone, 1);
    check(fall_cnt == NINIT, "R3 wake-up count", fall_cnt, NINIT);
    // R7 periodic refresh
    t0 = cyc;
    wait_fall(t1);
    check(t1 - t0 == REF + 3, "R7 first slot", t1 - t0, REF + 3);
    wait_fall(t2);
    check(t2 - t1 == REF, "R7 interval", t2 - t1, REF);
    wait_fall(t3);
    check(t3 - t2 == REF, "R7 interval", t3 - t2, REF);
    // R8 backlog with saturation: four slots while withheld
    wait_rise();
    gnt = 1'b0;
    base = fall_cnt;
    repeat (250) step();
    check(fall_cnt == base, "R6 no cycle without grant", fall_cnt, base);
    check(req == 1'b1 && drv == 1'b0, "R8 request pending", {req, drv}, 2);
    gnt = 1'b1;
    wait_fall(t1);
    wait_fall(t2);
    wait_fall(t3);
    check(t2 - t1 == BTB, "R8 back to back", t2 - t1, BTB);
    check(t3 - t2 == BTB, "R8 back to back", t3 - t2, BTB);
    repeat (15) step();
    check(fall_cnt == base + MOWED, "R8 capped backlog", fall_cnt - base, MOWED);
    // R10 external activity keeps the memory awake
    wait_fall(t1);
    wait_rise();
    gnt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      repeat (190) step();
      ext_ras_n = 1'b0;
      step();
      ext_ras_n = 1'b1;
    end
    check(idone == 1'b1, "R10 still awake", idone, 1);
    gnt = 1'b1;
    repeat (100) step();
    wait_fall(ta);
    wait_fall(tb);
    check(tb - ta == REF, "R7 cadence restored", tb - ta, REF);
    // R9 idle expiry
    wait_rise();
    c = cyc;
    gnt = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (!idone) break;
      step();
    end
    check(cyc - c == IDLE, "R9 idle limit", cyc - c, IDLE);
    gnt = 1'b1;
    base = fall_cnt;
    c = cyc;
    wait_fall(t1);
    check(t1 - c == 2, "R9 no pause on re-wake", t1 - c, 2);
    for (int i = 0; i < 200; i++) begin
      if (idone) break;
      step();
    end
    check(cyc - c == 72, "R9 re-wake length", cyc - c, 72);
    check(fall_cnt - base == NINIT, "R9 re-wake count", fall_cnt - base, NINIT);
    t0 = cyc;
    wait_fall(t1);
    check(t1 - t0 == REF + 3, "R9 backlog dropped", t1 - t0, REF + 3);
    check(viol == 0, "R6 strobes only when driving", viol, 0);
    // R1 reset mid-run
    rst = 1'b1;
    step();
    check(ras_n && cas_n && !req && !drv && !idone, "R1 reset mid-run",
          {ras_n, cas_n, req, drv, idone}, 5'b11000);
    finish_run();
  end
endmodule